// File: doc/BRIEF.md
# I2C Touch-Controller Slave Interface

This block is the serial front end of a resistive touch-screen controller. It listens to a two-wire I2C bus as a slave, oversampling the clock and data lines with a fast system clock. A write transfer carries one control byte. The block latches that byte and keeps it as the active command. A read transfer returns the latest conversion result, most significant bit first.

Every read transfer, including one that follows a repeated START, marks a new analog sample window and a new conversion period under the command already held. The master never has to resend the command between reads.

The successive-approximation converter itself sits outside this block. Its result arrives as a word on an input port, and this block captures that word when the sample window closes. The block gives strobes for command completion and for the end of the sample window. It also raises a busy flag that covers the conversion clocks, so the converter and the touch-panel drivers can follow the bus timing.

Top module: `tsc_i2c_slave`

## Requirements
- R1: The slave answers the address formed by the seven bits 1001 0, 0, `addr_sel` (in that order, MSB first), with the eighth bit as R/W (1 = read), by pulling SDA low during the ninth clock. On any other address it gives no acknowledge and keeps SDA released until the next START or STOP.
- R2: In a write transfer, the byte after the address is latched into `cmd_q` on its eighth SCL rising edge, `cmd_stb` pulses for one cycle, and the byte is acknowledged. `cmd_q` holds 8'h80 after reset and changes at no other time.
- R3: With command bit 1 (MODE) equal to 0, a read returns result bits 11..4 in the first byte and bits 3..0 followed by four zeros in the second byte.
- R4: With MODE equal to 1, the first byte carries result bits 11..4. Every later byte the master acknowledges is 8'h00. In 12-bit mode every byte after the second is also 8'h00.
- R5: After each data byte the slave releases SDA and samples the master's acknowledge. On NACK it drives nothing until the next START or STOP.
- R6: On the eighth SCL rising edge of a matching read address byte, `hold_stb` pulses for one cycle and `result_i` is captured for transmission.
- R7: Each read transfer, including one after a repeated START, captures a fresh result under the unchanged last command.
- R8: `conv_busy` rises after `hold_stb` and falls after 12 further SCL rising edges. The master-acknowledge clocks are not counted. A START or STOP clears it.
- R9: SDA is released after a STOP, and `sda_oe` changes only while the filtered SCL is low.
- R10: A pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks has no effect on bus decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL as seen on the bus |
| sda_i | input | 1 | SDA as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_sel | input | 1 | Strapped value of the lowest address bit |
| result_i | input | RES_W | Conversion result from the converter |
| cmd_q | output | 8 | Active command byte |
| cmd_stb | output | 1 | One-cycle pulse when a command byte is latched |
| hold_stb | output | 1 | One-cycle pulse at the close of the sample window |
| conv_busy | output | 1 | High during the conversion clocks |

## Verification
The bench builds the block with its defaults: a 12-bit result, a two-stage synchronizer, a three-sample filter and a 12-clock conversion window. With a 12-bit result, the 12-bit mode's second byte carries real data, so the nibble padding and the later zero bytes can be seen on the wire. The three-sample filter lets two-cycle pulses on either line test the glitch rejection. The 12-clock window ends inside the second data byte, so a single two-byte read shows the busy flag both set and cleared.

// File: rtl/tsc_pkg.sv
// Shared types and constants for the touch-controller serial slave.
// Assumes: one command byte per write, results of 9 to 16 bits.
package tsc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_ACK_WAIT,
        ST_ACK_DRV,
        ST_TX,
        ST_TX_ACK,
        ST_TX_NEXT,
        ST_SKIP
    } xfer_st_t;

    localparam int          CMD_MODE_BIT = 1;      // 1 = 8-bit output
    localparam logic [7:0]  CMD_RESET    = 8'h80;  // S=1, channel 000, PD0=0, MODE=0
    localparam logic [5:0]  ADDR_FIXED   = 6'b100100;

endpackage

// File: rtl/tsc_line_filter.sv
// Synchronizes one bus line and rejects pulses shorter than FILT_LEN samples.
// Assumes: the line idles high; the output moves only when FILT_LEN samples agree.
module tsc_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    hist_q;

    // Metastability chain followed by the sample history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
        end
    end

    // Output follows only a unanimous history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_o <= 1'b1;
        end else if (&hist_q) begin
            line_o <= 1'b1;
        end else if (~|hist_q) begin
            line_o <= 1'b0;
        end
    end
endmodule

// File: rtl/tsc_bus_events.sv
// Turns filtered SCL/SDA into edge and START/STOP pulses.
// Assumes: inputs are already synchronous and glitch-free.
module tsc_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_q, sda_q;

    // Previous filtered levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Edge and condition decode
    always_comb begin
        scl_rise = scl_f & ~scl_q;
        scl_fall = ~scl_f & scl_q;
        start_ev = scl_f & scl_q & sda_q & ~sda_f;
        stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
    end
endmodule

// File: rtl/tsc_conv_track.sv
// Tracks the conversion period: a fixed number of SCL rising edges after the
// sample window closes, skipping master-acknowledge clocks.
// Assumes: hold_stb and bus events come from the same clock domain.
module tsc_conv_track #(
    parameter int CONV_CLKS = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_stb,
    input  logic scl_rise,
    input  logic mack_phase,
    input  logic start_ev,
    input  logic stop_ev,
    output logic conv_busy
);
    localparam int CNT_W = $clog2(CONV_CLKS + 1);

    logic [CNT_W-1:0] cnt_q;

    // Busy window and counted SCL edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_busy <= 1'b0;
            cnt_q     <= '0;
        end else if (start_ev || stop_ev) begin
            conv_busy <= 1'b0;
            cnt_q     <= '0;
        end else if (hold_stb) begin
            conv_busy <= 1'b1;
            cnt_q     <= '0;
        end else if (conv_busy && scl_rise && !mack_phase) begin
            if (cnt_q == CNT_W'(CONV_CLKS - 1)) begin
                conv_busy <= 1'b0;
            end
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tsc_xfer_fsm.sv
// Byte engine: address match, command latch, acknowledge generation and
// result transmission with master acknowledge handling.
// Assumes: SDA driven only after a filtered SCL falling edge.
module tsc_xfer_fsm
    import tsc_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_ev,
    input  logic             stop_ev,
    input  logic             sda_f,
    input  logic             addr_sel,
    input  logic [RES_W-1:0] result_i,
    output logic             sda_oe,
    output logic [7:0]       cmd_q,
    output logic             cmd_stb,
    output logic             hold_stb,
    output logic             mack_phase
);
    localparam int LOW_W = RES_W - 8;
    localparam int PAD_W = 8 - LOW_W;

    xfer_st_t         st_q, after_ack_q;
    logic [3:0]       bit_cnt_q;
    logic [7:0]       shreg_q;
    logic [7:0]       tx_sh_q;
    logic [1:0]       byte_idx_q;
    logic [RES_W-1:0] res_q;
    logic [7:0]       first_byte, next_byte;
    logic             mode8;

    // Bytes to send, chosen by index and output resolution
    always_comb begin
        mode8      = cmd_q[CMD_MODE_BIT];
        first_byte = res_q[RES_W-1 -: 8];
        if (byte_idx_q == 2'd1 && !mode8) begin
            next_byte = {res_q[LOW_W-1:0], {PAD_W{1'b0}}};
        end else begin
            next_byte = 8'h00;
        end
        mack_phase = (st_q == ST_TX_ACK);
    end

    // Transfer state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            after_ack_q <= ST_SKIP;
            bit_cnt_q   <= '0;
            shreg_q     <= '0;
            tx_sh_q     <= '0;
            byte_idx_q  <= '0;
            res_q       <= '0;
            sda_oe      <= 1'b0;
            cmd_q       <= CMD_RESET;
            cmd_stb     <= 1'b0;
            hold_stb    <= 1'b0;
        end else begin
            cmd_stb  <= 1'b0;
            hold_stb <= 1'b0;
            if (start_ev) begin
                st_q      <= ST_ADDR;
                bit_cnt_q <= '0;
                sda_oe    <= 1'b0;
            end else if (stop_ev) begin
                st_q   <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (st_q)
                    ST_ADDR, ST_CMD: begin
                        if (scl_rise) begin
                            shreg_q   <= {shreg_q[6:0], sda_f};
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                            if (bit_cnt_q == 4'd7) begin
                                if (st_q == ST_CMD) begin
                                    cmd_q       <= {shreg_q[6:0], sda_f};
                                    cmd_stb     <= 1'b1;
                                    st_q        <= ST_ACK_WAIT;
                                    after_ack_q <= ST_SKIP;
                                end else if (shreg_q[6:0] == {ADDR_FIXED, addr_sel}) begin
                                    st_q        <= ST_ACK_WAIT;
                                    after_ack_q <= sda_f ? ST_TX : ST_CMD;
                                    if (sda_f) begin
                                        hold_stb <= 1'b1;
                                        res_q    <= result_i;
                                    end
                                end else begin
                                    st_q <= ST_SKIP;
                                end
                            end
                        end
                    end
                    ST_ACK_WAIT: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b1;
                            st_q   <= ST_ACK_DRV;
                        end
                    end
                    ST_ACK_DRV: begin
                        if (scl_fall) begin
                            bit_cnt_q <= '0;
                            st_q      <= after_ack_q;
                            if (after_ack_q == ST_TX) begin
                                tx_sh_q    <= first_byte;
                                sda_oe     <= ~first_byte[7];
                                byte_idx_q <= 2'd1;
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end else if (scl_fall) begin
                            if (bit_cnt_q == 4'd8) begin
                                sda_oe <= 1'b0;
                                st_q   <= ST_TX_ACK;
                            end else begin
                                tx_sh_q <= {tx_sh_q[6:0], 1'b0};
                                sda_oe  <= ~tx_sh_q[6];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            st_q <= sda_f ? ST_SKIP : ST_TX_NEXT;
                        end
                    end
                    ST_TX_NEXT: begin
                        if (scl_fall) begin
                            tx_sh_q   <= next_byte;
                            sda_oe    <= ~next_byte[7];
                            bit_cnt_q <= '0;
                            st_q      <= ST_TX;
                            if (byte_idx_q != 2'd3) begin
                                byte_idx_q <= byte_idx_q + 1'b1;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/tsc_i2c_slave.sv
// Top of the touch-controller serial slave: line filters, bus event decode,
// byte engine and conversion tracker.
// Assumes: clk runs at least 20 times faster than SCL; no clock stretching.
module tsc_i2c_slave #(
    parameter int RES_W       = 12,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3,
    parameter int CONV_CLKS   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic             addr_sel,
    input  logic [RES_W-1:0] result_i,
    output logic [7:0]       cmd_q,
    output logic             cmd_stb,
    output logic             hold_stb,
    output logic             conv_busy
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines, filt_lines;
    logic scl_f, sda_f;
    logic scl_rise, scl_fall, start_ev, stop_ev;
    logic mack_phase;

    assign raw_lines = {sda_i, scl_i};
    assign scl_f     = filt_lines[0];
    assign sda_f     = filt_lines[1];

    // One synchronizer and filter per bus line
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        tsc_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(raw_lines[g]),
            .line_o(filt_lines[g])
        );
    end

    tsc_bus_events u_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (scl_f),
        .sda_f   (sda_f),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .start_ev(start_ev),
        .stop_ev (stop_ev)
    );

    tsc_xfer_fsm #(
        .RES_W(RES_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev),
        .sda_f     (sda_f),
        .addr_sel  (addr_sel),
        .result_i  (result_i),
        .sda_oe    (sda_oe),
        .cmd_q     (cmd_q),
        .cmd_stb   (cmd_stb),
        .hold_stb  (hold_stb),
        .mack_phase(mack_phase)
    );

    tsc_conv_track #(
        .CONV_CLKS(CONV_CLKS)
    ) u_conv (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_stb  (hold_stb),
        .scl_rise  (scl_rise),
        .mack_phase(mack_phase),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev),
        .conv_busy (conv_busy)
    );
endmodule

// File: rtl/tsc_i2c_slave_chk.sv
// Protocol checks on the serial slave, attached to the top by bind.
module tsc_i2c_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_f,
    input logic       start_ev,
    input logic       stop_ev,
    input logic       sda_oe,
    input logic       cmd_stb,
    input logic [7:0] cmd_q,
    input logic       hold_stb,
    input logic       conv_busy
);
    // R9
    oe_quiet_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f) && !$past(start_ev) && !$past(stop_ev))
            |-> (sda_oe == $past(sda_oe)));

    // R9
    release_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe);

    // R1
    release_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> !sda_oe);

    // R2
    cmd_only_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_stb |-> $stable(cmd_q));

    // R8
    hold_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_stb |=> conv_busy);

    // R6
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hold_stb, cmd_stb}));
endmodule

bind tsc_i2c_slave tsc_i2c_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .sda_oe   (sda_oe),
    .cmd_stb  (cmd_stb),
    .cmd_q    (cmd_q),
    .hold_stb (hold_stb),
    .conv_busy(conv_busy)
);

// File: tb/tsc_i2c_slave_tb.sv
// Scoreboard bench: tasks push expected bytes, a monitor compares observed ones.
module tsc_i2c_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 20;
    localparam int RES_W      = 12;

    typedef struct {
        string      req;
        logic [7:0] val;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic addr_sel = 1'b1;
    logic [RES_W-1:0] result_i = '0;
    logic sda_oe, cmd_stb, hold_stb, conv_busy;
    logic [7:0] cmd_q;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    int hold_cnt = 0;
    bit oe_seen = 0;
    bit done = 0;
    exp_t exp_q[$];
    logic [7:0] obs_q[$];

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    tsc_i2c_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .addr_sel(addr_sel), .result_i(result_i),
        .cmd_q(cmd_q), .cmd_stb(cmd_stb), .hold_stb(hold_stb),
        .conv_busy(conv_busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: collect strobes, compare observed items with expected ones
    always @(negedge clk) begin
        if (rst_n) begin
            if (sda_oe) oe_seen = 1'b1;
            if (hold_stb) hold_cnt++;
            if (cmd_stb) obs_q.push_back(cmd_q);
            while (obs_q.size() > 0) begin
                logic [7:0] o;
                o = obs_q.pop_front();
                if (exp_q.size() == 0) begin
                    chk("R2", o, 32'hFFFF_FFFF, "unexpected item");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(e.req, o, e.val, "scoreboard item");
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(HALF);
        scl_m = 1'b1; tick(HALF);
        sda_m = 1'b0; tick(HALF);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(HALF);
        scl_m = 1'b1; tick(HALF);
        sda_m = 1'b1; tick(HALF);
    endtask

    task automatic bit_xfer(input logic b, output logic r, input bit glitch);
        sda_m = b; tick(HALF);
        scl_m = 1'b1;
        if (glitch) begin
            tick(4);  sda_m = 1'b0; tick(2); sda_m = 1'b1;
            tick(4);  scl_m = 1'b0; tick(2); scl_m = 1'b1;
            tick(HALF - 12);
            r = sda_line;
        end else begin
            tick(HALF/2); r = sda_line; tick(HALF/2);
        end
        scl_m = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack, input bit glitch);
        logic r;
        for (int i = 7; i >= 0; i--) bit_xfer(b[i], r, glitch && (i == 7));
        bit_xfer(1'b1, r, 1'b0);
        ack = ~r;
    endtask

    task automatic read_bits(output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, r, 1'b0);
            d[i] = r;
        end
    endtask

    task automatic master_ack(input bit ack);
        logic r;
        bit_xfer(ack ? 1'b0 : 1'b1, r, 1'b0);
    endtask

    task automatic write_cmd(input logic [7:0] addr, input logic [7:0] c, input string req,
                             input bit glitch);
        logic ack;
        exp_t e;
        e.req = req; e.val = c; exp_q.push_back(e);
        bus_start();
        write_byte(addr, ack, glitch);
        chk("R1", ack, 1, "address ack on write");
        write_byte(c, ack, glitch);
        chk(req, ack, 1, "command ack");
        bus_stop();
        chk("R9", sda_oe, 0, "released after stop");
    endtask

    // Read n bytes after a START or repeated START; last byte is NACKed
    task automatic read_xfer(input logic [7:0] addr, input logic [RES_W-1:0] w,
                             input logic [7:0] e0, input logic [7:0] e1,
                             input logic [7:0] e2, input int n, input string req);
        logic ack;
        logic [7:0] d;
        logic [7:0] ev [3];
        exp_t e;
        ev[0] = e0; ev[1] = e1; ev[2] = e2;
        result_i = w;
        bus_start();
        write_byte(addr, ack, 1'b0);
        chk("R1", ack, 1, "address ack on read");
        for (int k = 0; k < n; k++) begin
            e.req = req; e.val = ev[k]; exp_q.push_back(e);
            read_bits(d);
            obs_q.push_back(d);
            master_ack(k < n - 1);
        end
    endtask

    initial begin
        logic ack;
        logic [7:0] d;
        exp_t e;
        int h0;
        tick(5);
        // Reset state (R2)
        chk("R2", cmd_q, 8'h80, "command after reset");
        chk("R9", sda_oe, 0, "sda released in reset");
        chk("R8", conv_busy, 0, "busy in reset");
        rst_n = 1'b1;
        tick(10);
        chk("R2", cmd_q, 8'h80, "command after reset release");

        // Write 12-bit x-axis command (R2)
        write_cmd(8'h92, 8'hC0, "R2", 1'b0);
        chk("R2", cmd_q, 8'hC0, "command latched");

        // 12-bit read with busy window tracking (R3, R6, R8)
        h0 = hold_cnt;
        result_i = 12'hA5C;
        bus_start();
        write_byte(8'h93, ack, 1'b0);
        chk("R1", ack, 1, "read address ack");
        chk("R6", hold_cnt, h0 + 1, "one hold strobe per read");
        chk("R8", conv_busy, 1, "busy after sample window");
        e.req = "R3"; e.val = 8'hA5; exp_q.push_back(e);
        read_bits(d); obs_q.push_back(d);
        chk("R8", conv_busy, 1, "busy after nine counted clocks");
        master_ack(1);
        e.req = "R3"; e.val = 8'hC0; exp_q.push_back(e);
        read_bits(d); obs_q.push_back(d);
        chk("R8", conv_busy, 0, "busy ends after twelve counted clocks");
        master_ack(0);
        bus_stop();
        chk("R9", sda_oe, 0, "released after read stop");

        // Continuous reads through repeated START (R7)
        h0 = hold_cnt;
        read_xfer(8'h93, 12'h3F1, 8'h3F, 8'h10, 8'h00, 2, "R7");
        read_xfer(8'h93, 12'h7E2, 8'h7E, 8'h20, 8'h00, 2, "R7");
        bus_stop();
        chk("R7", hold_cnt, h0 + 2, "fresh sample per repeated start");
        chk("R7", cmd_q, 8'hC0, "command kept across reads");

        // 8-bit mode (R4), busy cleared by STOP (R8)
        write_cmd(8'h92, 8'hD2, "R4", 1'b0);
        read_xfer(8'h93, 12'hBCD, 8'hBC, 8'h00, 8'h00, 2, "R4");
        bus_stop();
        read_xfer(8'h93, 12'h9F7, 8'h9F, 8'h00, 8'h00, 1, "R4");
        chk("R8", conv_busy, 1, "busy still open before stop");
        bus_stop();
        chk("R8", conv_busy, 0, "busy cleared by stop");

        // 12-bit mode, third byte is zero (R4, R3)
        write_cmd(8'h92, 8'hC0, "R2", 1'b0);
        read_xfer(8'h93, 12'h123, 8'h12, 8'h30, 8'h00, 3, "R4");
        bus_stop();

        // NACK stops the slave (R5)
        read_xfer(8'h93, 12'h000, 8'h00, 8'h00, 8'h00, 1, "R5");
        oe_seen = 1'b0;
        read_bits(d);
        chk("R5", oe_seen, 0, "no drive after nack");
        chk("R5", d, 8'hFF, "bus idle after nack");
        bus_stop();

        // Address mismatch (R1)
        addr_sel = 1'b0;
        tick(4);
        bus_start();
        oe_seen = 1'b0;
        write_byte(8'h93, ack, 1'b0);
        chk("R1", ack, 0, "no ack on mismatch");
        read_bits(d);
        chk("R1", oe_seen, 0, "sda released after mismatch");
        bus_stop();
        h0 = hold_cnt;
        read_xfer(8'h91, 12'h5A5, 8'h5A, 8'h50, 8'h00, 2, "R1");
        bus_stop();
        chk("R6", hold_cnt, h0 + 1, "hold on matched address only");

        // Short pulses on both lines are ignored (R10)
        write_cmd(8'h90, 8'hE4, "R10", 1'b1);
        chk("R10", cmd_q, 8'hE4, "command intact despite pulses");

        tick(20);
        chk("R2", exp_q.size(), 0, "all expected items seen");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule